// File: doc/BRIEF.md
# Interval Timer Counter Channel

A single 16-bit down-counting channel of a programmable interval timer, together with the decoder for the shared control word. Software programs the channel with a control word that picks the counting mode, then loads the 16-bit period as two byte writes, low byte first. The count drops by one on each cycle in which the tick enable input is high and the channel is running. The nominal tick rate is about 1.19318 MHz, produced by a divider outside this block. The output pin shows terminal count, a rate pulse or a square wave, depending on the mode.

Reads return the count one byte at a time, low byte first. A latch command takes a snapshot of the running count, so a 16-bit value can be read without tearing while counting goes on. Settings the channel does not support raise sticky error flags, and the word that carried them is discarded.

Control word bits: select [7:6], access [5:4], mode [3:1], BCD [0].

Top module: `pit_counter_channel`

## Requirements
- R1: After reset the count is 0, the output is low, all three error flags are low, and both the read and write byte pointers select the low byte.
- R2: A control word is taken only when select [7:6] equals the parameter CHAN_SEL. Select 3 (read-back) sets the sticky flag errReadBack. Any other select leaves the channel unchanged.
- R3: Access field [5:4] value 0 is a latch command and value 3 (low then high byte) is accepted. Values 1 or 2, or BCD bit [0] set, raise the sticky flag errAccess, and the word is discarded.
- R4: Mode field [3:1] accepts 0, 2 and 3. Any other mode raises the sticky flag errMode and leaves the stored mode unchanged.
- R5: With no latch held, each read returns the byte of the live count that the read pointer selects, and the pointer then flips between low and high byte.
- R6: A latch command with no latch held copies the count into the latch and points reads at the low byte. Reads then come from the latch. Reading the latched high byte releases the latch. A latch command while a latch is held has no effect.
- R7: A data write to the low byte replaces the count's low byte, halts counting and drives the output low. Ticks have no effect until the high byte is written.
- R8: A data write to the high byte replaces the count's high byte and copies the whole count into the period. Counting starts only if the period is nonzero. The output goes high in modes 2 and 3 and stays low in mode 0.
- R9: In mode 0 the tick that takes the count from 1 to 0 drives the output high. The channel then stops at 0 with the output high.
- R10: In mode 2 the tick at count 1 reloads the period and drives the output low. The next tick drives it high again, which gives one low tick per period.
- R11: In mode 3 the count reloads at 1 and the output is high for ceil(P/2) ticks and low for floor(P/2) ticks of each period P.
- R12: A data write in the same cycle as a tick takes priority, and the tick is lost. Ticks while the channel is halted change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control word write strobe |
| dataWr | input | 1 | Data byte write strobe |
| dataRd | input | 1 | Data byte read strobe; advances the read pointer |
| wrData | input | 8 | Write byte for control and data writes |
| tickEn | input | 1 | Count enable at the timer tick rate |
| rdData | output | 8 | Byte currently selected for reading |
| timerOut | output | 1 | Channel output pin |
| errReadBack | output | 1 | Sticky: read-back select seen |
| errAccess | output | 1 | Sticky: unsupported access or BCD |
| errMode | output | 1 | Sticky: unsupported mode |

## Verification
The three modes are run with small periods: mode 2 with period 3, mode 3 with period 4, and mode 0 with period 2. The output trace tells apart the one-tick low pulse, the even high/low split and the single rising edge followed by a stop. Reads taken while the count moves, before and after a latch, show whether the latched snapshot or the live count is returned, and a second latch command is issued to show it is ignored. Data writes sent in the same cycle as a tick, a zero period, and rejected or foreign control words followed by a mode-0 run show that those inputs leave the count, the output and the stored mode as required.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // control word field positions (decoded by the channel and its neighbours)
  localparam int SEL_LSB  = 6;
  localparam int ACC_LSB  = 4;
  localparam int MODE_LSB = 1;
  localparam int BCD_BIT  = 0;

  localparam logic [1:0] SEL_READBACK = 2'd3;
  localparam logic [1:0] ACC_LATCH    = 2'd0;
  localparam logic [1:0] ACC_LOHI     = 2'd3;

  typedef enum logic [2:0] {
    MODE_TC     = 3'd0,
    MODE_RATE   = 3'd2,
    MODE_SQUARE = 3'd3
  } timerMode_e;

  typedef struct packed {
    logic       loadLo;
    logic       loadHi;
    logic       snap;
    logic       tickStep;
    logic       readMsb;
    logic       useLatch;
    timerMode_e mode;
  } pitStrobes_t;

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHAN_SEL = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              countIsOne,
  input  logic              loNonZero,
  output pitStrobes_t       stb,
  output logic              errReadBack,
  output logic              errAccess,
  output logic              errMode
);

  localparam logic [1:0] MY_SEL = 2'(CHAN_SEL);

  logic [1:0] selF, accF;
  logic [2:0] modeF;
  logic       bcdF;
  logic       ctrlHit, latchCmd, progCmd, accOk, modeOk;
  logic       wrPtrMsb, rdPtrMsb, latchHeld, running;
  timerMode_e modeReg;
  logic       snap, loadLo, loadHi, tickStep, startRun;

  assign selF  = wrData[SEL_LSB+:2];
  assign accF  = wrData[ACC_LSB+:2];
  assign modeF = wrData[MODE_LSB+:3];
  assign bcdF  = wrData[BCD_BIT];

  assign ctrlHit  = ctrlWr && (selF == MY_SEL) && (selF != SEL_READBACK);
  assign latchCmd = ctrlHit && (accF == ACC_LATCH);
  assign progCmd  = ctrlHit && (accF != ACC_LATCH);
  assign accOk    = (accF == ACC_LOHI) && !bcdF;
  assign modeOk   = (modeF == MODE_TC) || (modeF == MODE_RATE) || (modeF == MODE_SQUARE);

  assign snap     = latchCmd && !latchHeld;
  assign loadLo   = dataWr && !wrPtrMsb;
  assign loadHi   = dataWr && wrPtrMsb;
  assign tickStep = tickEn && running && !dataWr;
  assign startRun = (wrData != '0) || loNonZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtrMsb    <= 1'b0;
      rdPtrMsb    <= 1'b0;
      latchHeld   <= 1'b0;
      running     <= 1'b0;
      modeReg     <= MODE_TC;
      errReadBack <= 1'b0;
      errAccess   <= 1'b0;
      errMode     <= 1'b0;
    end else begin
      if (ctrlWr && selF == SEL_READBACK) errReadBack <= 1'b1;
      if (progCmd && !accOk)  errAccess <= 1'b1;
      if (progCmd && !modeOk) errMode   <= 1'b1;
      if (progCmd && accOk && modeOk) modeReg <= timerMode_e'(modeF);

      if (snap) begin
        latchHeld <= 1'b1;
        rdPtrMsb  <= 1'b0;
      end else if (dataRd) begin
        rdPtrMsb <= !rdPtrMsb;
        if (latchHeld && rdPtrMsb) latchHeld <= 1'b0;
      end

      if (dataWr) wrPtrMsb <= !wrPtrMsb;

      if (loadLo)                                             running <= 1'b0;
      else if (loadHi)                                        running <= startRun;
      else if (tickStep && modeReg == MODE_TC && countIsOne)  running <= 1'b0;
    end
  end

  always_comb begin
    stb.loadLo   = loadLo;
    stb.loadHi   = loadHi;
    stb.snap     = snap;
    stb.tickStep = tickStep;
    stb.readMsb  = rdPtrMsb;
    stb.useLatch = latchHeld;
    stb.mode     = modeReg;
  end

  AST_WAIT_MSB_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    wrPtrMsb |-> !running);                                             // R7
  AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    latchHeld && dataRd && rdPtrMsb |=> !latchHeld);                    // R6
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    latchHeld && !dataRd |=> latchHeld && $stable(rdPtrMsb));           // R6
  AST_RB_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errReadBack |=> errReadBack);                                       // R2

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pitStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              timerOut,
  output logic              countIsOne,
  output logic              loNonZero
);

  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] count, period, latchReg, halfMark, readSrc;
  logic             outReg;

  assign countIsOne = (count == CNT_W'(1));
  assign loNonZero  = (count[DATA_W-1:0] != '0);
  assign halfMark   = (period >> 1) + CNT_W'(1);
  assign readSrc    = stb.useLatch ? latchReg : count;
  assign rdData     = stb.readMsb ? readSrc[CNT_W-1:DATA_W] : readSrc[DATA_W-1:0];
  assign timerOut   = outReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      period   <= '0;
      latchReg <= '0;
      outReg   <= 1'b0;
    end else begin
      if (stb.snap) latchReg <= count;
      if (stb.loadLo) begin
        count[DATA_W-1:0] <= wrData;
        outReg            <= 1'b0;
      end else if (stb.loadHi) begin
        count[CNT_W-1:DATA_W] <= wrData;
        period                <= {wrData, count[DATA_W-1:0]};
        outReg                <= (stb.mode != MODE_TC);
      end else if (stb.tickStep) begin
        case (stb.mode)
          MODE_RATE: begin
            if (countIsOne) begin
              count  <= period;
              outReg <= 1'b0;
            end else begin
              count  <= count - CNT_W'(1);
              outReg <= 1'b1;
            end
          end
          MODE_SQUARE: begin
            if (countIsOne) begin
              count  <= period;
              outReg <= 1'b1;
            end else begin
              count <= count - CNT_W'(1);
              if (count == halfMark) outReg <= 1'b0;
            end
          end
          default: begin
            count <= count - CNT_W'(1);
            if (countIsOne) outReg <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_TC_OUT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    stb.tickStep && stb.mode == MODE_TC && countIsOne |=> timerOut && count == '0); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tickStep && !stb.loadLo && !stb.loadHi |=> $stable(count));                // R12
  AST_PERIODIC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.tickStep && stb.mode != MODE_TC |=> count != '0);                            // R10

endmodule

// File: rtl/pit_counter_channel.sv
module pit_counter_channel
  import pit_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHAN_SEL = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  output logic [DATA_W-1:0] rdData,
  output logic              timerOut,
  output logic              errReadBack,
  output logic              errAccess,
  output logic              errMode
);

  pitStrobes_t stb;
  logic        countIsOne, loNonZero;

  pit_ctrl #(.DATA_W(DATA_W), .CHAN_SEL(CHAN_SEL)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .dataWr(dataWr), .dataRd(dataRd),
    .tickEn(tickEn), .wrData(wrData), .countIsOne(countIsOne), .loNonZero(loNonZero),
    .stb(stb), .errReadBack(errReadBack), .errAccess(errAccess), .errMode(errMode)
  );

  pit_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdData(rdData),
    .timerOut(timerOut), .countIsOne(countIsOne), .loNonZero(loNonZero)
  );

endmodule

// File: tb/pit_counter_channel_tb.sv
module pit_counter_channel_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0, dataWr = 1'b0, dataRd = 1'b0, tickEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       timerOut, errReadBack, errAccess, errMode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pit_counter_channel #(.DATA_W(8), .CHAN_SEL(0)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .dataWr(dataWr), .dataRd(dataRd),
    .wrData(wrData), .tickEn(tickEn), .rdData(rdData), .timerOut(timerOut),
    .errReadBack(errReadBack), .errAccess(errAccess), .errMode(errMode)
  );

  // ops: 0 control, 1 data write, 2 tick, 3 read ; {op, data, expOut, expRd}
  localparam int NVEC = 18;
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 8'h34, 1'b0, 8'h00},  // R10 mode 2
    {2'd1, 8'h03, 1'b0, 8'h00},
    {2'd1, 8'h00, 1'b1, 8'h00},  // R8 start high
    {2'd2, 8'h00, 1'b1, 8'h00},
    {2'd2, 8'h00, 1'b1, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00},  // R10 low pulse
    {2'd2, 8'h00, 1'b1, 8'h00},
    {2'd3, 8'h00, 1'b1, 8'h02},  // R5
    {2'd3, 8'h00, 1'b1, 8'h00},
    {2'd1, 8'h04, 1'b0, 8'h00},  // R7
    {2'd0, 8'h36, 1'b0, 8'h00},  // R11 mode 3
    {2'd1, 8'h00, 1'b1, 8'h00},
    {2'd2, 8'h00, 1'b1, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b1, 8'h00},
    {2'd2, 8'h00, 1'b1, 8'h00},
    {2'd2, 8'h00, 1'b0, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doCtrl(input logic [7:0] b);
    @(negedge clk); ctrlWr = 1'b1; wrData = b;
    @(negedge clk); ctrlWr = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] b, input logic withTick);
    @(negedge clk); dataWr = 1'b1; wrData = b; tickEn = withTick;
    @(negedge clk); dataWr = 1'b0; tickEn = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic doRead(output logic [7:0] b);
    @(negedge clk); dataRd = 1'b1; #1 b = rdData;
    @(negedge clk); dataRd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 out", timerOut, 0);
    check("R1 rd", rdData, 0);
    check("R1 errs", {errReadBack, errAccess, errMode}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      logic [7:0] d;
      op = VEC[i][18:17];
      d  = VEC[i][16:9];
      rb = 8'h00;
      case (op)
        2'd0: doCtrl(d);
        2'd1: doWrite(d, 1'b0);
        2'd2: doTick();
        default: doRead(rb);
      endcase
      #1;
      check($sformatf("R10/R11 vec%0d out", i), timerOut, VEC[i][8]);
      if (op == 2'd3) check($sformatf("R5 vec%0d rd", i), rb, VEC[i][7:0]);
    end

    // mode 0 terminal count, R9
    doWrite(8'h02, 1'b0);
    doCtrl(8'h30);
    doWrite(8'h00, 1'b0);
    #1 check("R8 mode0 low at start", timerOut, 0);
    doTick();
    #1 check("R9 before tc", timerOut, 0);
    doTick();
    #1 check("R9 at tc", timerOut, 1);
    doTick();
    #1 check("R9 stays high", timerOut, 1);
    doRead(rb); check("R9 stopped lsb", rb, 8'h00);
    doRead(rb); check("R9 stopped msb", rb, 8'h00);

    // zero period does not start, R8
    doWrite(8'h00, 1'b0);
    doWrite(8'h00, 1'b0);
    #1 check("R8 zero period out", timerOut, 0);
    doTick();
    doRead(rb); check("R8 zero period lsb", rb, 8'h00);
    doRead(rb); check("R8 zero period msb", rb, 8'h00);

    // latch, R6
    doWrite(8'h10, 1'b0);
    doWrite(8'h00, 1'b0);
    doTick(); doTick();
    doCtrl(8'h00);
    doTick();
    doCtrl(8'h00);
    doTick();
    doRead(rb); check("R6 latched lsb", rb, 8'h0E);
    doRead(rb); check("R6 latched msb", rb, 8'h00);
    doRead(rb); check("R6 live lsb after release", rb, 8'h0C);
    doRead(rb); check("R6 live msb", rb, 8'h00);

    // write priority over tick, R12 / R7
    doWrite(8'h05, 1'b1);
    #1 check("R7 out low after lsb", timerOut, 0);
    doTick();
    doRead(rb); check("R12 halted lsb", rb, 8'h05);
    doRead(rb); check("R12 halted msb", rb, 8'h00);
    doWrite(8'h00, 1'b1);
    doRead(rb); check("R12 tick lost on msb write", rb, 8'h05);
    doRead(rb); check("R12 msb", rb, 8'h00);
    doTick();
    doRead(rb); check("R12 counting resumed", rb, 8'h04);
    doRead(rb);

    // rejected and foreign control words, R2 R3 R4
    doCtrl(8'hC0);
    #1 check("R2 readback flag", errReadBack, 1);
    check("R3 access clean", errAccess, 0);
    doCtrl(8'h10);
    #1 check("R3 access 1 flag", errAccess, 1);
    check("R4 mode clean", errMode, 0);
    doCtrl(8'h38);
    #1 check("R4 mode 4 flag", errMode, 1);
    doCtrl(8'h74);
    doCtrl(8'h35);
    #1 check("R2 flags sticky", {errReadBack, errAccess, errMode}, 3'b111);
    doWrite(8'h02, 1'b0);
    doWrite(8'h00, 1'b0);
    #1 check("R4 mode 0 kept, out low", timerOut, 0);
    doTick();
    #1 check("R2 foreign word ignored", timerOut, 0);
    doTick();
    #1 check("R4 mode 0 kept, tc high", timerOut, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule